// File: doc/BRIEF.md
# Configurable LCD Pixel Unpacker

This block turns a stream of 32-bit framebuffer words into a stream of 24-bit RGB pixels, one pixel per output beat. A format register sets how many bits each pixel takes and how the pixels are ordered inside a word. It also sets the 16-bit colour layout and whether red and blue trade places. Words arrive on a valid/ready input. The block holds each word until every pixel it carries has been handed to the valid/ready output.

At depths of 8 bits or less, each unpacked value is an index into a 256-entry, 16-bit palette. Software fills the palette through a word-wide write port that carries two entries per write. The palette read takes one cycle. That cycle overlaps the output register stage, so indexed and direct-colour pixels leave with the same latency: one cycle after the input is taken.

Top module: `pxu_top`

## Requirements
- R1: After reset, out_valid and in_ready are low, and the format register is zero. Zero means 1 bpp, ordering code 0, no swap and sub-format 0.
- R2: Format bits [2:0] set the depth. Codes 0 to 4 give 1, 2, 4, 8 and 16 bpp. Code 5 (and 6 and 7) gives 24 bpp. A word therefore yields 32, 16, 8, 4, 2 or 1 pixels. in_ready is high only when the last pixel of the current word is being loaded, so each word is accepted exactly once, after all of its pixels.
- R3: Format bits [4:3] set the ordering, with pixel k of b bits.
  - Code 0 (and code 3) takes bits starting at k*b.
  - Code 1 counts from the top of the word and takes bits starting at 32-(k+1)*b.
  - Code 2 walks the bytes upward, and inside each byte takes the pixels from the most significant end. At 8, 16 and 24 bpp, code 2 acts as code 0.
- R4: At 16 bpp, format bits [7:6] pick the colour layout.
  - 0 (and 3): red [15:11], green [10:5], blue [4:0].
  - 1: red [14:10], green [9:5], blue [4:0]; bit 15 is ignored.
  - 2: red [11:8], green [7:4], blue [3:0]; bits [15:12] are ignored.
- R5: At 24 bpp, the pixel is bits [23:0] of the word for orderings 0, 2 and 3, and bits [31:8] for ordering 1. Red is in the top byte of that field, blue in the low byte.
- R6: At 1, 2, 4 and 8 bpp, the unpacked value addresses the palette. The 16-bit entry is decoded as red [15:11], green [10:5], blue [4:0].
- R7: A palette write to word address a stores pal_wdata[15:0] in entry 2a and pal_wdata[31:16] in entry 2a+1.
- R8: Colour fields narrower than 8 bits widen to 8 bits by repeating their top bits in the low bits (5-bit x becomes {x, x[4:2]}, 6-bit becomes {x, x[5:4]}, 4-bit becomes {x, x}).
- R9: Format bit 5 swaps the red and blue bytes of out_pixel. The output is normally red [23:16], green [15:8], blue [7:0].
- R10: While out_valid is high and out_ready is low, out_pixel holds its value, in_ready stays low, and no pixel is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Format register write strobe |
| cfg_wdata | input | 8 | Format value: [2:0] depth, [4:3] ordering, [5] red/blue swap, [7:6] 16-bit layout |
| pal_we | input | 1 | Palette write strobe |
| pal_waddr | input | 7 | Palette word address (entry pair) |
| pal_wdata | input | 32 | Two palette entries, even entry in the low half |
| in_valid | input | 1 | Framebuffer word valid |
| in_data | input | 32 | Framebuffer word |
| in_ready | output | 1 | Word accepted at this edge when in_valid is also high |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_pixel | output | 24 | RGB888 pixel |

## Verification
The bench first runs a table of hand-worked words. Each one targets a single choice: 565 against 555 against 444 with junk in the unused top bits, and little against big ordering of 16-bit halves. Other rows cover 1 bpp under all three orderings, 24 bpp under both field positions, the red/blue swap, and palette lookup. After that, a pseudo-random word is pushed through every depth, ordering, swap and sub-format combination. Each pixel is compared with an independent model, and the pixel count per word is checked, so any mistake in slot offsets or in the consumption point shows up. Directed sequences then cover the reset state, a long output stall in the middle of a word, and a palette pair rewrite that tells the even entry from the odd one.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  typedef struct packed {
    logic [1:0] sub;    // 16-bit colour layout
    logic       swap;   // red/blue exchange
    logic [1:0] order;  // pixel ordering in word
    logic [2:0] depth;  // bits-per-pixel code
  } pxu_fmt_t;

  typedef enum logic [1:0] {
    SRC_PAL = 2'd0,
    SRC_16  = 2'd1,
    SRC_24  = 2'd2
  } pxu_src_t;

  function automatic int bits_of(input logic [2:0] depth);
    case (depth)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic [4:0] last_slot(input logic [2:0] depth);
    case (depth)
      3'd0: return 5'd31;
      3'd1: return 5'd15;
      3'd2: return 5'd7;
      3'd3: return 5'd3;
      3'd4: return 5'd1;
      default: return 5'd0;
    endcase
  endfunction

  // Lowest bit position of a pixel slot inside a 32-bit word
  function automatic logic [4:0] bit_offset(input logic [2:0] depth,
                                            input logic [1:0] order,
                                            input logic [4:0] slot);
    int b;
    int lin;
    int off;
    b   = bits_of(depth);
    lin = int'(slot) * b;
    case (order)
      2'd1: off = 32 - lin - b;
      2'd2: off = (b < 8) ? ((lin & ~7) + 8 - (lin & 7) - b) : lin;
      default: off = lin;
    endcase
    return 5'(off);
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] x);
    return {x, x[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] x);
    return {x, x[5:4]};
  endfunction

  function automatic logic [7:0] widen4(input logic [3:0] x);
    return {x, x};
  endfunction

  // 16-bit colour word to RGB888 for a given layout code
  function automatic logic [23:0] rgb_from16(input logic [15:0] v,
                                             input logic [1:0] sub);
    case (sub)
      2'd1: return {widen5(v[14:10]), widen5(v[9:5]), widen5(v[4:0])};
      2'd2: return {widen4(v[11:8]), widen4(v[7:4]), widen4(v[3:0])};
      default: return {widen5(v[15:11]), widen6(v[10:5]), widen5(v[4:0])};
    endcase
  endfunction

endpackage

// File: rtl/pxu_palette.sv
module pxu_palette #(
  parameter int ENTRIES = 256,
  parameter int ENTRY_W = 16,
  parameter int WORD_W  = 32,
  localparam int LANES  = WORD_W / ENTRY_W,
  localparam int AW     = $clog2(ENTRIES),
  localparam int LSEL_W = $clog2(LANES),
  localparam int BANK_D = ENTRIES / LANES,
  localparam int WA_W   = AW - LSEL_W
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WA_W-1:0]    waddr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               re,
  input  logic [AW-1:0]      raddr,
  output logic [ENTRY_W-1:0] rdata
);

  logic [ENTRY_W-1:0] bank_rd [LANES];
  logic [LSEL_W-1:0]  sel_q;

  for (genvar l = 0; l < LANES; l++) begin : g_bank
    logic [ENTRY_W-1:0] mem [BANK_D];
    logic [ENTRY_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata[l*ENTRY_W +: ENTRY_W];
      if (re) rd_q <= mem[raddr[AW-1:LSEL_W]];
    end
    assign bank_rd[l] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (re) sel_q <= raddr[LSEL_W-1:0];
  end

  assign rdata = bank_rd[sel_q];

endmodule

// File: rtl/pxu_slicer.sv
module pxu_slicer
  import pxu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int RAW_W  = 24,
  localparam int SLOT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word,
  input  pxu_fmt_t          fmt,
  input  logic [SLOT_W-1:0] slot,
  output logic [RAW_W-1:0]  raw,
  output logic              last,
  output pxu_src_t          src
);

  logic [4:0]        off;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] mask;

  always_comb begin
    off     = bit_offset(fmt.depth, fmt.order, slot);
    shifted = word >> off;
    mask    = (WORD_W'(1) << bits_of(fmt.depth)) - WORD_W'(1);
    raw     = RAW_W'(shifted & mask);
    last    = (slot == last_slot(fmt.depth));
    if (fmt.depth <= 3'd3)      src = SRC_PAL;
    else if (fmt.depth == 3'd4) src = SRC_16;
    else                        src = SRC_24;
  end

endmodule

// File: rtl/pxu_colorize.sv
module pxu_colorize
  import pxu_pkg::*;
#(
  parameter int RAW_W   = 24,
  parameter int ENTRY_W = 16
) (
  input  logic [RAW_W-1:0]   raw,
  input  pxu_src_t           src,
  input  logic [1:0]         sub,
  input  logic               swap,
  input  logic [ENTRY_W-1:0] pal,
  output logic [23:0]        pixel
);

  logic [23:0] rgb;

  always_comb begin
    case (src)
      SRC_PAL: rgb = rgb_from16(pal, 2'd0);
      SRC_16:  rgb = rgb_from16(raw[15:0], sub);
      default: rgb = raw[23:0];
    endcase
    pixel = swap ? {rgb[7:0], rgb[15:8], rgb[23:16]} : rgb;
  end

endmodule

// File: rtl/pxu_top.sv
module pxu_top
  import pxu_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int PAL_ENTRIES = 256,
  parameter int PAL_ENTRY_W = 16,
  localparam int PIX_W      = 24,
  localparam int SLOT_W     = $clog2(WORD_W),
  localparam int PAL_AW     = $clog2(PAL_ENTRIES),
  localparam int PAL_WA_W   = $clog2(PAL_ENTRIES / (WORD_W / PAL_ENTRY_W))
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [$bits(pxu_fmt_t)-1:0] cfg_wdata,
  input  logic                      pal_we,
  input  logic [PAL_WA_W-1:0]       pal_waddr,
  input  logic [WORD_W-1:0]         pal_wdata,
  input  logic                      in_valid,
  input  logic [WORD_W-1:0]         in_data,
  output logic                      in_ready,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [PIX_W-1:0]          out_pixel
);

  pxu_fmt_t           fmt_q;
  logic [SLOT_W-1:0]  slot_q;

  logic               s_valid;
  logic [PIX_W-1:0]   s_raw;
  pxu_src_t           s_src;
  logic [1:0]         s_sub;
  logic               s_swap;

  logic [PIX_W-1:0]   cut_raw;
  logic               cut_last;
  pxu_src_t           cut_src;
  logic [PAL_ENTRY_W-1:0] pal_rd;

  // named events
  logic stage_free;
  logic load;
  logic word_done;

  assign stage_free = !s_valid || out_ready;
  assign load       = in_valid && stage_free;
  assign word_done  = load && cut_last;
  assign in_ready   = stage_free && cut_last;

  always_ff @(posedge clk) begin
    if (rst)         fmt_q <= '0;
    else if (cfg_we) fmt_q <= pxu_fmt_t'(cfg_wdata);
  end

  always_ff @(posedge clk) begin
    if (rst)            slot_q <= '0;
    else if (word_done) slot_q <= '0;
    else if (load)      slot_q <= slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_raw   <= '0;
      s_src   <= SRC_PAL;
      s_sub   <= '0;
      s_swap  <= 1'b0;
    end else if (load) begin
      s_valid <= 1'b1;
      s_raw   <= cut_raw;
      s_src   <= cut_src;
      s_sub   <= fmt_q.sub;
      s_swap  <= fmt_q.swap;
    end else if (out_ready) begin
      s_valid <= 1'b0;
    end
  end

  pxu_slicer #(.WORD_W(WORD_W), .RAW_W(PIX_W)) u_slicer (
    .word (in_data),
    .fmt  (fmt_q),
    .slot (slot_q),
    .raw  (cut_raw),
    .last (cut_last),
    .src  (cut_src)
  );

  pxu_palette #(.ENTRIES(PAL_ENTRIES), .ENTRY_W(PAL_ENTRY_W), .WORD_W(WORD_W)) u_pal (
    .clk   (clk),
    .we    (pal_we),
    .waddr (pal_waddr),
    .wdata (pal_wdata),
    .re    (load),
    .raddr (cut_raw[PAL_AW-1:0]),
    .rdata (pal_rd)
  );

  pxu_colorize #(.RAW_W(PIX_W), .ENTRY_W(PAL_ENTRY_W)) u_color (
    .raw   (s_raw),
    .src   (s_src),
    .sub   (s_sub),
    .swap  (s_swap),
    .pal   (pal_rd),
    .pixel (out_pixel)
  );

  assign out_valid = s_valid;

endmodule

// File: rtl/pxu_checker.sv
module pxu_checker (
  input logic        clk,
  input logic        rst,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_pixel,
  input logic        in_ready,
  input logic        load,
  input logic        word_done,
  input logic [2:0]  depth
);

  logic [6:0] pix_cnt;
  logic [6:0] ppw;

  always_ff @(posedge clk) begin
    if (rst)            pix_cnt <= '0;
    else if (word_done) pix_cnt <= '0;
    else if (load)      pix_cnt <= pix_cnt + 7'd1;
  end

  always_comb begin
    case (depth)
      3'd0: ppw = 7'd32;
      3'd1: ppw = 7'd16;
      3'd2: ppw = 7'd8;
      3'd3: ppw = 7'd4;
      3'd4: ppw = 7'd2;
      default: ppw = 7'd1;
    endcase
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pixel));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R2
  word_count_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |-> (pix_cnt + 7'd1 == ppw));

  // R2
  load_emits_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> out_valid);

  // R6
  pixel_known_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_pixel));

endmodule

bind pxu_top pxu_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pixel (out_pixel),
  .in_ready  (in_ready),
  .load      (load),
  .word_done (word_done),
  .depth     (fmt_q.depth)
);

// File: tb/tb_pxu_top.sv
module tb_pxu_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        pal_we = 1'b0;
  logic [6:0]  pal_waddr = '0;
  logic [31:0] pal_wdata = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_pixel;

  always #5 clk = ~clk;

  pxu_top dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] palm [256];
  logic [23:0] cap [32];
  int ncap;

  // {fmt, word, slot, expected}; palette entry i holds {~i, i}
  localparam logic [71:0] VEC [13] = '{
    {8'h04, 32'h1234F800, 8'd0, 24'hFF0000},  // R4 565 low half
    {8'h04, 32'h1234F800, 8'd1, 24'h1045A5},  // R8 replication
    {8'h0C, 32'h1234F800, 8'd0, 24'h1045A5},  // R3 big-endian halves
    {8'h44, 32'h0000FC00, 8'd0, 24'hFF0000},  // R4 555 ignores bit 15
    {8'h84, 32'h0000FABC, 8'd0, 24'hAABBCC},  // R4 444 ignores top nibble
    {8'h05, 32'h99123456, 8'd0, 24'h123456},  // R5 low field
    {8'h0D, 32'h12345699, 8'd0, 24'h123456},  // R5 high field
    {8'h25, 32'h00123456, 8'd0, 24'h563412},  // R9 swap
    {8'h03, 32'h00000005, 8'd0, 24'hFF4129},  // R6 palette lookup
    {8'h10, 32'h00000080, 8'd0, 24'hFFC308},  // R3 order 2 slot 0
    {8'h10, 32'h00000080, 8'd7, 24'hFFE300},  // R3 order 2 slot 7
    {8'h00, 32'h00000080, 8'd7, 24'hFFC308},  // R3 order 0 slot 7
    {8'h08, 32'h80000000, 8'd0, 24'hFFC308}   // R3 order 1 slot 0
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] f);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = f;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pal_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    pal_we = 1'b1; pal_waddr = a; pal_wdata = d;
    @(negedge clk);
    pal_we = 1'b0;
    palm[{a, 1'b0}] = d[15:0];
    palm[{a, 1'b1}] = d[31:16];
  endtask

  task automatic run_word(input logic [31:0] w);
    bit fin = 0;
    bit pend = 0;
    int guard = 0;
    ncap = 0;
    while (!fin && guard < 200) begin
      @(negedge clk);
      guard++;
      if (out_valid) begin
        if (ncap < 32) cap[ncap] = out_pixel;
        ncap++;
      end
      if (pend) begin
        in_valid = 1'b0;
        fin = 1;
      end else begin
        in_valid = 1'b1;
        in_data = w;
        if (in_ready) pend = 1;
      end
    end
  endtask

  function automatic int ppw_of(input logic [2:0] d);
    return (d >= 3'd5) ? 1 : (32 >> d);
  endfunction

  function automatic logic [23:0] mdl(input logic [7:0] f, input logic [31:0] w, input int k);
    int d, o, sb, b, pos, bi, wi, r, g, bl, h, kind;
    longint unsigned wu, rawv;
    d = int'(f[2:0]); o = int'(f[4:3]); sb = int'(f[7:6]);
    b = (d >= 5) ? 24 : (1 << d);
    if (o == 1) pos = 32 - (k + 1) * b;
    else if (o == 2 && b < 8) begin
      bi = (k * b) / 8; wi = (k * b) % 8;
      pos = bi * 8 + (7 - wi) - (b - 1);
    end else pos = k * b;
    wu = longint'(w);
    rawv = (wu >> pos) & ((64'd1 << b) - 64'd1);
    kind = 0; h = 0;
    if (d <= 3) h = int'(palm[rawv[7:0]]);
    else if (d == 4) begin
      h = int'(rawv);
      kind = (sb == 1) ? 1 : (sb == 2) ? 2 : 0;
    end
    if (d >= 5) begin
      r = int'((rawv >> 16) & 255); g = int'((rawv >> 8) & 255); bl = int'(rawv & 255);
    end else if (kind == 1) begin
      r = (h >> 10) & 31; g = (h >> 5) & 31; bl = h & 31;
      r = r * 8 + r / 4; g = g * 8 + g / 4; bl = bl * 8 + bl / 4;
    end else if (kind == 2) begin
      r = ((h >> 8) & 15) * 17; g = ((h >> 4) & 15) * 17; bl = (h & 15) * 17;
    end else begin
      r = (h >> 11) & 31; g = (h >> 5) & 63; bl = h & 31;
      r = r * 8 + r / 4; g = g * 4 + g / 16; bl = bl * 8 + bl / 4;
    end
    if (f[5]) return {8'(bl), 8'(g), 8'(r)};
    return {8'(r), 8'(g), 8'(bl)};
  endfunction

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state, 1 bpp so the first slot is not the last
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    check(in_ready == 1'b0, "R1 in_ready", 32'(in_ready), 0);

    for (int a = 0; a < 128; a++)
      pal_write(7'(a), {~8'(2*a+1), 8'(2*a+1), ~8'(2*a), 8'(2*a)});

    // vector table
    for (int i = 0; i < 13; i++) begin
      logic [7:0]  f;
      logic [31:0] w;
      logic [7:0]  s;
      logic [23:0] e;
      {f, w, s, e} = VEC[i];
      cfg_write(f);
      run_word(w);
      check(cap[s[4:0]] == e, $sformatf("R3/R4/R5/R6/R8/R9 vec%0d", i), 32'(cap[s[4:0]]), 32'(e));
    end

    // R10: stall with a 16 bpp word mid-way
    cfg_write(8'h04);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 32'h1234F800;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      check(out_valid && out_pixel == 24'hFF0000, "R10 held pixel", 32'(out_pixel), 32'hFF0000);
      check(in_ready == 1'b0, "R10 in_ready low", 32'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_pixel == 24'h1045A5, "R10 second pixel", 32'(out_pixel), 32'h1045A5);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 drained", 32'(out_valid), 0);

    // R7: pair write, even entry in the low half
    pal_write(7'd2, 32'h001F_F800);
    cfg_write(8'h03);
    run_word(32'h0000_0504);
    check(cap[0] == 24'hFF0000, "R7 even entry", 32'(cap[0]), 32'hFF0000);
    check(cap[1] == 24'h0000FF, "R7 odd entry", 32'(cap[1]), 32'h0000FF);

    // sweep against the model
    lf = 32'hC0DE_1357;
    for (int d = 0; d < 6; d++)
      for (int o = 0; o < 4; o++)
        for (int sw = 0; sw < 2; sw++)
          for (int sb = 0; sb < ((d == 4) ? 4 : 1); sb++) begin
            logic [7:0] f;
            f = {2'(sb), 1'(sw), 2'(o), 3'(d)};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} ^ 32'h9E37_79B9;
            cfg_write(f);
            run_word(lf);
            // R2: pixels per word
            check(ncap == ppw_of(3'(d)), $sformatf("R2 count fmt=%h", f), 32'(ncap), 32'(ppw_of(3'(d))));
            for (int k = 0; k < ppw_of(3'(d)) && k < ncap; k++)
              check(cap[k] == mdl(f, lf, k), $sformatf("R3 fmt=%h slot=%0d", f, k),
                    32'(cap[k]), 32'(mdl(f, lf, k)));
          end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule